// File: doc/BRIEF.md
# Windowed Transfer Data Buffer

This block is the staging store between a 32-bit host register port and a flash sequencer. It holds 512 bytes, organised as 128 words of four byte lanes each. The host does not address this storage directly. It programs a control register with a direction flag, an auto-advance flag and a word pointer, and then moves whole words through one data register. An access in the allowed direction advances the pointer by one word when auto-advance is set.

The sequencer works on bytes. Before a transfer, software programs a separate engine start address. A load pulse copies that address into the engine's byte pointer, and every engine access then moves one byte and steps the pointer. Bytes map onto words in little-endian order. A transfer whose length is not a multiple of four therefore leaves its trailing bytes in the low lanes of the last word. Software moves that word as one full 32-bit access.

Both sides share one single-ported store. The engine wins every cycle it asks for. A host data-register access that meets an engine access is held off by `host_ready` until the store is free.

Top module: `xfer_dbuf`

## Requirements
- R1: After reset, reads of the control register (select 0) and of the engine start register (select 2) both return 0.
- R2: The control register holds the direction at bit 31 (1 = host writes into the buffer, 0 = host reads from it), auto-advance at bit 30, and the word pointer in bits 7:0. Pointer bits at or above log2(word count) are dropped and read back as 0.
- R3: With direction 1, a host write to the data register (select 1) stores the full word at the pointer. With auto-advance set, the pointer then steps to the next word.
- R4: With direction 0, a host read of the data register returns the word at the pointer. `host_rvalid` rises in the cycle after acceptance. With auto-advance set, the pointer then steps.
- R5: With auto-advance clear, data-register accesses leave the pointer where it is, so repeated accesses hit the same word.
- R6: The pointer wraps from the last word (127) to word 0.
- R7: A data-register read while the direction is 1 returns 0. A data-register write while the direction is 0 stores nothing. Neither one moves the pointer.
- R8: Engine byte address b maps to word b/4, lane b mod 4, with lane 0 at bits 7:0. Engine read data appears on `eng_rdata` with `eng_rvalid` in the cycle after the request.
- R9: `eng_load` copies the start register (bits 8:0 of the written word) into the engine byte pointer. Each engine access moves one byte and steps the pointer, which wraps from 511 to 0.
- R10: An engine request takes priority. While `eng_valid` is high, `host_ready` is low for data-register accesses. The held host access completes in the next cycle that has no engine request.
- R11: When the engine writes a byte count that is not a multiple of four, the trailing bytes occupy the low lanes of the last word read by the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host register access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register select: 0 control, 1 data, 2 engine start |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Host access accepted this cycle |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 32 | Host read data |
| eng_load | input | 1 | Load engine byte pointer from start register |
| eng_valid | input | 1 | Engine byte access request |
| eng_write | input | 1 | 1 = engine writes a byte |
| eng_wdata | input | 8 | Engine write byte |
| eng_rvalid | output | 1 | Engine read byte valid |
| eng_rdata | output | 8 | Engine read byte |

## Verification
The bench builds the block with its default size of 512 bytes, which gives 128 words, a 7-bit word pointer and a 9-bit engine pointer. Because the pointer can be loaded straight to 127 and the start register to 511, both wrap points are reached within a few accesses. Dropping pointer bit 7 shows up in the control readback. An engine transfer of five bytes produces the partial trailing word, and a same-cycle request from both sides exercises the stall.

// File: rtl/dbuf_pkg.sv
// Package: shared constants and the host register select encoding for the
// windowed transfer buffer. Assumes a 32-bit host word split into bytes.
package dbuf_pkg;
    localparam int HOST_DW   = 32;
    localparam int LANE_W    = 8;
    localparam int LANES     = HOST_DW / LANE_W;
    localparam int DIR_BIT   = 31;
    localparam int INC_BIT   = 30;
    localparam int PTR_FIELD = 8;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_START = 2'd2,
        SEL_NONE  = 2'd3
    } host_sel_e;
endpackage

// File: rtl/dbuf_host_regs.sv
// Host-side register file: control (direction, auto-advance, word pointer)
// and engine start address. Decides whether an accepted data-register access
// may reach the store. Assumes WORDS is a power of two and PTR_W <= 8.
module dbuf_host_regs
    import dbuf_pkg::*;
#(
    parameter int WORDS   = 128,
    parameter int BYTES   = 512,
    localparam int PTR_W  = $clog2(WORDS),
    localparam int BADDR_W = $clog2(BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc,
    input  logic               host_write,
    input  logic [1:0]         host_addr,
    input  logic               wr_dir,
    input  logic               wr_inc,
    input  logic [PTR_W-1:0]   wr_ptr,
    input  logic [BADDR_W-1:0] wr_start,
    output logic               cfg_dir,
    output logic               cfg_inc,
    output logic [PTR_W-1:0]   word_ptr,
    output logic [BADDR_W-1:0] start_addr,
    output logic               host_mem_en,
    output logic               host_mem_we,
    output logic               rd_ok,
    output logic [HOST_DW-1:0] reg_rdata
);
    logic data_hit;
    logic dir_ok;

    // Decode: a data access goes ahead only in the programmed direction.
    always_comb begin
        data_hit    = acc && (host_addr == SEL_DATA);
        dir_ok      = host_write ? cfg_dir : !cfg_dir;
        host_mem_en = data_hit && dir_ok;
        host_mem_we = host_mem_en && host_write;
        rd_ok       = !cfg_dir;
    end

    // Readback value of the control and start registers.
    always_comb begin
        reg_rdata = '0;
        case (host_addr)
            SEL_CTRL: begin
                reg_rdata[DIR_BIT]   = cfg_dir;
                reg_rdata[INC_BIT]   = cfg_inc;
                reg_rdata[PTR_W-1:0] = word_ptr;
            end
            SEL_START: reg_rdata[BADDR_W-1:0] = start_addr;
            default:   reg_rdata = '0;
        endcase
    end

    // Register updates: control/start writes and pointer advance with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_dir    <= 1'b0;
            cfg_inc    <= 1'b0;
            word_ptr   <= '0;
            start_addr <= '0;
        end else if (acc && host_write && host_addr == SEL_CTRL) begin
            cfg_dir  <= wr_dir;
            cfg_inc  <= wr_inc;
            word_ptr <= wr_ptr;
        end else if (acc && host_write && host_addr == SEL_START) begin
            start_addr <= wr_start;
        end else if (host_mem_en && cfg_inc) begin
            word_ptr <= (word_ptr == PTR_W'(WORDS - 1)) ? '0 : word_ptr + PTR_W'(1);
        end
    end
endmodule

// File: rtl/dbuf_eng_ptr.sv
// Engine byte pointer: loaded from the start address, stepped by one byte per
// engine access. Assumes BYTES is a power of two so the step wraps naturally.
module dbuf_eng_ptr #(
    parameter int BYTES    = 512,
    localparam int BADDR_W = $clog2(BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eng_load,
    input  logic               eng_valid,
    input  logic [BADDR_W-1:0] start_addr,
    output logic [BADDR_W-1:0] eng_addr
);
    logic [BADDR_W-1:0] ptr_q;

    // Current address: a load in the same cycle takes effect at once.
    always_comb eng_addr = eng_load ? start_addr : ptr_q;

    // Pointer register: step after each access, else follow a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (eng_valid)
            ptr_q <= eng_addr + BADDR_W'(1);
        else if (eng_load)
            ptr_q <= start_addr;
    end
endmodule

// File: rtl/dbuf_word_mem.sv
// Single-port word store with per-lane write enables and a registered read.
// Each lane is its own byte array. The array content has no reset. A read
// during a write returns the old content.
module dbuf_word_mem #(
    parameter int WORDS  = 128,
    parameter int LANES  = 4,
    localparam int AW    = $clog2(WORDS),
    localparam int DW    = LANES * 8
) (
    input  logic             clk,
    input  logic             en,
    input  logic [LANES-1:0] be,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_mem [WORDS];
        logic [7:0] q;

        // Lane access: optional byte write, registered read of old content.
        always_ff @(posedge clk) begin
            if (en) begin
                if (be[g])
                    lane_mem[addr] <= wdata[g*8 +: 8];
                q <= lane_mem[addr];
            end
        end

        assign rdata[g*8 +: 8] = q;
    end
endmodule

// File: rtl/xfer_dbuf.sv
// Top: windowed transfer buffer shared by a host register port and a byte-wide
// sequencer port. The engine has fixed priority on the single store, and host
// data accesses stall while it is busy. Host and engine reads return one cycle
// after acceptance.
module xfer_dbuf
    import dbuf_pkg::*;
#(
    parameter int BYTES    = 512,
    localparam int WORDS   = BYTES / LANES,
    localparam int PTR_W   = $clog2(WORDS),
    localparam int BADDR_W = $clog2(BYTES),
    localparam int LSEL_W  = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_valid,
    input  logic               host_write,
    input  logic [1:0]         host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic               host_ready,
    output logic               host_rvalid,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic               eng_load,
    input  logic               eng_valid,
    input  logic               eng_write,
    input  logic [7:0]         eng_wdata,
    output logic               eng_rvalid,
    output logic [7:0]         eng_rdata
);
    logic               acc;
    logic               cfg_dir;
    logic               cfg_inc;
    logic [PTR_W-1:0]   word_ptr;
    logic [BADDR_W-1:0] start_addr;
    logic               host_mem_en;
    logic               host_mem_we;
    logic               rd_ok;
    logic [HOST_DW-1:0] reg_rdata;
    logic [BADDR_W-1:0] eng_addr;

    logic               mem_en;
    logic [LANES-1:0]   mem_be;
    logic [PTR_W-1:0]   mem_addr;
    logic [HOST_DW-1:0] mem_wdata;
    logic [HOST_DW-1:0] mem_rdata;

    logic               h_rvalid_q;
    logic               h_data_q;
    logic               h_ok_q;
    logic [HOST_DW-1:0] h_reg_q;
    logic               e_rvalid_q;
    logic [LSEL_W-1:0]  e_lane_q;

    // Stall rule: only data-register accesses compete with the engine.
    always_comb begin
        host_ready = !(eng_valid && host_addr == SEL_DATA);
        acc        = host_valid && host_ready;
    end

    dbuf_host_regs #(.WORDS(WORDS), .BYTES(BYTES)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .host_write (host_write),
        .host_addr  (host_addr),
        .wr_dir     (host_wdata[DIR_BIT]),
        .wr_inc     (host_wdata[INC_BIT]),
        .wr_ptr     (host_wdata[PTR_W-1:0]),
        .wr_start   (host_wdata[BADDR_W-1:0]),
        .cfg_dir    (cfg_dir),
        .cfg_inc    (cfg_inc),
        .word_ptr   (word_ptr),
        .start_addr (start_addr),
        .host_mem_en(host_mem_en),
        .host_mem_we(host_mem_we),
        .rd_ok      (rd_ok),
        .reg_rdata  (reg_rdata)
    );

    dbuf_eng_ptr #(.BYTES(BYTES)) eptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .eng_load  (eng_load),
        .eng_valid (eng_valid),
        .start_addr(start_addr),
        .eng_addr  (eng_addr)
    );

    // Store port mux: the engine first, the host otherwise.
    always_comb begin
        if (eng_valid) begin
            mem_en    = 1'b1;
            mem_addr  = eng_addr[BADDR_W-1:LSEL_W];
            mem_wdata = {LANES{eng_wdata}};
            mem_be    = '0;
            if (eng_write)
                mem_be[eng_addr[LSEL_W-1:0]] = 1'b1;
        end else begin
            mem_en    = host_mem_en;
            mem_addr  = word_ptr;
            mem_wdata = host_wdata;
            mem_be    = {LANES{host_mem_we}};
        end
    end

    dbuf_word_mem #(.WORDS(WORDS), .LANES(LANES)) mem_i (
        .clk  (clk),
        .en   (mem_en),
        .be   (mem_be),
        .addr (mem_addr),
        .wdata(mem_wdata),
        .rdata(mem_rdata)
    );

    // Read return state for both ports, captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rvalid_q <= 1'b0;
            h_data_q   <= 1'b0;
            h_ok_q     <= 1'b0;
            h_reg_q    <= '0;
            e_rvalid_q <= 1'b0;
            e_lane_q   <= '0;
        end else begin
            h_rvalid_q <= acc && !host_write;
            h_data_q   <= host_addr == SEL_DATA;
            h_ok_q     <= rd_ok;
            h_reg_q    <= reg_rdata;
            e_rvalid_q <= eng_valid && !eng_write;
            e_lane_q   <= eng_addr[LSEL_W-1:0];
        end
    end

    // Output formatting: a wrong-direction data read returns zero.
    always_comb begin
        host_rvalid = h_rvalid_q;
        if (!h_rvalid_q)
            host_rdata = '0;
        else if (h_data_q)
            host_rdata = h_ok_q ? mem_rdata : '0;
        else
            host_rdata = h_reg_q;
        eng_rvalid = e_rvalid_q;
        eng_rdata  = mem_rdata[e_lane_q*8 +: 8];
    end
endmodule

// File: rtl/dbuf_chk.sv
// Checker for xfer_dbuf, attached by bind. Watches the ports and the
// programmed pointer state for handshake, direction and pointer rules.
module dbuf_chk
    import dbuf_pkg::*;
#(
    parameter int WORDS = 128,
    localparam int PTR_W = $clog2(WORDS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_valid,
    input logic               host_write,
    input logic [1:0]         host_addr,
    input logic               host_ready,
    input logic               host_rvalid,
    input logic [HOST_DW-1:0] host_rdata,
    input logic               eng_valid,
    input logic               eng_write,
    input logic               eng_rvalid,
    input logic               cfg_dir,
    input logic               cfg_inc,
    input logic [PTR_W-1:0]   word_ptr
);
    logic data_acc;
    logic dir_ok;
    always_comb begin
        data_acc = host_valid && host_ready && host_addr == SEL_DATA;
        dir_ok   = host_write ? cfg_dir : !cfg_dir;
    end

    // R10
    stall_needs_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |-> eng_valid);

    // R4
    host_read_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && !host_write) |=> host_rvalid);

    // R8
    eng_read_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_write) |=> eng_rvalid);

    // R7
    wrong_dir_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !host_write && cfg_dir) |=> (host_rdata == '0));

    // R7
    wrong_dir_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !dir_ok) |=> $stable(word_ptr));

    // R5
    no_advance_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !cfg_inc) |=> $stable(word_ptr));

    // R6
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && dir_ok && cfg_inc && word_ptr == PTR_W'(WORDS - 1)) |=> (word_ptr == '0));
endmodule

bind xfer_dbuf dbuf_chk #(.WORDS(WORDS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_write (host_write),
    .host_addr  (host_addr),
    .host_ready (host_ready),
    .host_rvalid(host_rvalid),
    .host_rdata (host_rdata),
    .eng_valid  (eng_valid),
    .eng_write  (eng_write),
    .eng_rvalid (eng_rvalid),
    .cfg_dir    (cfg_dir),
    .cfg_inc    (cfg_inc),
    .word_ptr   (word_ptr)
);

// File: tb/xfer_dbuf_tb_top.sv
// Scoreboard bench: tasks drive accesses and queue expected read data from a
// byte model built from the requirements; a negedge monitor pops and compares.
module xfer_dbuf_tb_top;
    localparam int BYTES = 512;
    localparam int WORDS = BYTES / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic        host_rvalid;
    logic [31:0] host_rdata;
    logic        eng_load = 1'b0;
    logic        eng_valid = 1'b0;
    logic        eng_write = 1'b0;
    logic [7:0]  eng_wdata = '0;
    logic        eng_rvalid;
    logic [7:0]  eng_rdata;

    int tests = 0;
    int fails = 0;

    logic [31:0] h_exp_q [$];
    string       h_tag_q [$];
    logic [7:0]  e_exp_q [$];
    string       e_tag_q [$];

    logic [7:0] model [BYTES];
    int  hptr = 0;
    bit  hdir = 0;
    bit  hinc = 0;
    int  eptr = 0;
    int  start_reg = 0;

    always #2 clk = ~clk;

    xfer_dbuf #(.BYTES(BYTES)) dut_i (.*);

    function automatic logic [31:0] mword(int w);
        return {model[w*4+3], model[w*4+2], model[w*4+1], model[w*4]};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare returned reads against queued expectations.
    always @(negedge clk) begin
        if (host_rvalid) begin
            if (h_exp_q.size() == 0) check(0, "host extra read", host_rdata, '0);
            else begin
                automatic logic [31:0] e = h_exp_q.pop_front();
                automatic string t = h_tag_q.pop_front();
                check(host_rdata == e, t, host_rdata, e);
            end
        end
        if (eng_rvalid) begin
            if (e_exp_q.size() == 0) check(0, "engine extra read", {24'b0, eng_rdata}, '0);
            else begin
                automatic logic [7:0] e = e_exp_q.pop_front();
                automatic string t = e_tag_q.pop_front();
                check(eng_rdata == e, t, {24'b0, eng_rdata}, {24'b0, e});
            end
        end
    end

    // Host access with stall handling; updates the model per the rules.
    task automatic host_op(bit wr, logic [1:0] sel, logic [31:0] wd, string tag);
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = sel; host_wdata = wd;
        #1;
        while (!host_ready) begin @(negedge clk); #1; end
        if (sel == 2'd0 && wr) begin
            hdir = wd[31]; hinc = wd[30]; hptr = wd[6:0];
        end else if (sel == 2'd2 && wr) begin
            start_reg = wd[8:0];
        end else if (sel == 2'd0) begin
            h_exp_q.push_back({hdir, hinc, 23'b0, 7'(hptr)}); h_tag_q.push_back(tag);
        end else if (sel == 2'd2) begin
            h_exp_q.push_back(32'(start_reg)); h_tag_q.push_back(tag);
        end else if (sel == 2'd1) begin
            if (wr && hdir) begin
                for (int b = 0; b < 4; b++) model[hptr*4+b] = wd[b*8 +: 8];
                if (hinc) hptr = (hptr + 1) % WORDS;
            end else if (!wr && !hdir) begin
                h_exp_q.push_back(mword(hptr)); h_tag_q.push_back(tag);
                if (hinc) hptr = (hptr + 1) % WORDS;
            end else if (!wr) begin
                h_exp_q.push_back('0); h_tag_q.push_back(tag);
            end
        end
        @(posedge clk);
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic eng_ld();
        @(negedge clk); eng_load = 1'b1; eptr = start_reg;
        @(negedge clk); eng_load = 1'b0;
    endtask

    task automatic eng_op(bit wr, logic [7:0] wd, string tag);
        @(negedge clk);
        eng_valid = 1'b1; eng_write = wr; eng_wdata = wd;
        if (wr) model[eptr] = wd;
        else begin e_exp_q.push_back(model[eptr]); e_tag_q.push_back(tag); end
        eptr = (eptr + 1) % BYTES;
        @(posedge clk);
        @(negedge clk);
        eng_valid = 1'b0;
    endtask

    task automatic ctrl(bit d, bit i, int p);
        host_op(1, 2'd0, {d, i, 22'b0, 8'(p)}, "ctrl");
    endtask

    // Watchdog: a hung run ends as a failure with the summary line.
    initial begin
        #400000;
        fails++; tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        for (int i = 0; i < BYTES; i++) model[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Prime the store so the byte model matches it (dir=1, auto-advance).
        ctrl(1, 1, 0);
        for (int w = 0; w < WORDS; w++) host_op(1, 2'd1, mword(w), "prime");
        // R1 reset values: re-reset, then read both registers.
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        hdir = 0; hinc = 0; hptr = 0; start_reg = 0; eptr = 0;
        host_op(0, 2'd0, '0, "R1 control after reset");
        host_op(0, 2'd2, '0, "R1 start after reset");
        // R2 pointer field truncation and flag bits.
        ctrl(1, 1, 8'hFF);
        host_op(0, 2'd0, '0, "R2 control readback");
        // R3 host writes with auto-advance.
        ctrl(1, 1, 0);
        host_op(1, 2'd1, 32'hA1B2C3D4, "R3");
        host_op(1, 2'd1, 32'h01020304, "R3");
        host_op(1, 2'd1, 32'hDEADBEEF, "R3");
        // R4 host reads with auto-advance.
        ctrl(0, 1, 0);
        for (int k = 0; k < 3; k++) host_op(0, 2'd1, '0, "R3 R4 read back");
        // R5 no advance: same word twice.
        ctrl(0, 0, 2);
        host_op(0, 2'd1, '0, "R5 first");
        host_op(0, 2'd1, '0, "R5 repeat");
        // R6 wrap at the last word.
        ctrl(1, 1, WORDS - 1);
        host_op(1, 2'd1, 32'h5555AAAA, "R6");
        host_op(1, 2'd1, 32'h12345678, "R6");
        ctrl(0, 1, WORDS - 1);
        host_op(0, 2'd1, '0, "R6 last word");
        host_op(0, 2'd1, '0, "R6 wrapped word 0");
        // R7 wrong-direction read returns 0 and keeps the pointer.
        ctrl(1, 1, 5);
        host_op(0, 2'd1, '0, "R7 read while dir=1");
        host_op(1, 2'd1, 32'hCAFEF00D, "R7");
        ctrl(0, 1, 5);
        host_op(0, 2'd1, '0, "R7 word 5 after held pointer");
        // R7 wrong-direction write ignored, pointer held.
        host_op(1, 2'd1, 32'hBADBADBA, "R7");
        host_op(0, 2'd1, '0, "R7 word 6 untouched");
        host_op(0, 2'd1, '0, "R7 word 7");
        // R8 R11 engine writes five bytes from start 0.
        host_op(1, 2'd2, 32'd0, "start");
        eng_ld();
        for (int b = 0; b < 5; b++) eng_op(1, 8'(8'h90 + b), "R8");
        ctrl(0, 1, 0);
        host_op(0, 2'd1, '0, "R8 R11 full word");
        host_op(0, 2'd1, '0, "R11 trailing word low lane");
        // R8 R9 engine reads from byte 40 (word 10) lane order.
        ctrl(1, 0, 10);
        host_op(1, 2'd1, 32'h44332211, "R8");
        host_op(1, 2'd2, 32'd40, "start");
        host_op(0, 2'd2, '0, "R9 start readback");
        eng_ld();
        for (int b = 0; b < 4; b++) eng_op(0, '0, "R8 R9 byte order");
        // R9 engine pointer wraps 511 -> 0.
        host_op(1, 2'd2, 32'd511, "start");
        eng_ld();
        eng_op(1, 8'hE1, "R9");
        eng_op(1, 8'hE2, "R9");
        eng_ld();
        eng_op(0, '0, "R9 byte 511");
        eng_op(0, '0, "R9 byte 0 after wrap");
        // R10 collision: engine read and host data read in one cycle.
        host_op(1, 2'd2, 32'd12, "start");
        eng_ld();
        ctrl(0, 0, 3);
        @(negedge clk);
        eng_valid = 1'b1; eng_write = 1'b0;
        e_exp_q.push_back(model[12]); e_tag_q.push_back("R10 engine served");
        host_valid = 1'b1; host_write = 1'b0; host_addr = 2'd1;
        h_exp_q.push_back(mword(3)); h_tag_q.push_back("R10 host after stall");
        #1 check(host_ready == 1'b0, "R10 stall", {31'b0, host_ready}, 32'd0);
        @(negedge clk);
        eng_valid = 1'b0;
        #1 check(host_ready == 1'b1, "R10 released", {31'b0, host_ready}, 32'd1);
        @(negedge clk);
        host_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(h_exp_q.size() == 0 && e_exp_q.size() == 0, "R4 R8 all reads returned",
              32'(h_exp_q.size() + e_exp_q.size()), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule